// File: doc/BRIEF.md
# Host Bus Type Auto-Detector

This block sits at the host side of a peripheral that attaches to an 8-bit microcontroller bus. It works out which bus protocol the host uses, so that no glue logic and no extra configuration pins are needed. After a hardware reset it watches the first accesses on the bus and answers two questions.

The first question is about the control pins. They carry either a separate read strobe and write strobe, or a direction level and a data strobe. The second question is about addresses: are they time-shared with data and latched by an address strobe (multiplexed), or driven on their own address pins (non-multiplexed)? Software settles both questions with a write followed by an odd-address read before it relies on the peripheral. The first chip-selected read freezes both answers until the next hardware reset.

The block synchronises all pins to its clock. It then turns the raw pins into clean internal read, write and address-valid levels, and gives the internal address for the register file behind it. It also reports the two detected styles and whether they are frozen.

Top module: `host_bus_autodetect`

## Requirements
- R1: After reset, `ctl_dirstb`=0 (separate strobes), `bus_split`=0 (multiplexed), `modes_locked`=0, and `rd_stb`, `wr_stb`, `addr_vld` are all 0.
- R2: While unlocked, a falling edge on `ctl_a_n` while `ctl_b_n` is low sets `ctl_dirstb` to 1 (direction-plus-strobe style). This happens whether or not `cs_n` is asserted.
- R3: While unlocked, `addr_pin[0]` high during any access (`ctl_a_n` low or `ctl_b_n` low) sets `bus_split` to 1 (non-multiplexed). A multiplexed host keeps bit 0 low.
- R4: In both styles, a read is `ctl_a_n` low with `ctl_b_n` high. With `cs_n` low this drives `rd_stb`=1 and sets `modes_locked`=1.
- R5: Once `modes_locked`=1, no bus activity changes `ctl_dirstb` or `bus_split`.
- R6: A write needs `cs_n` low. In separate-strobe style it is `ctl_b_n` low with `ctl_a_n` high. In direction-plus-strobe style it is both pins low. A write drives `wr_stb`=1.
- R7: With `cs_n` high, `rd_stb` and `wr_stb` stay 0 and a read pattern does not lock the modes.
- R8: In multiplexed style, the falling edge of `ale` captures `data_pin` into `addr_out`. `addr_vld` is then 1 while `cs_n` is low, until `ale` rises again.
- R9: In non-multiplexed style, `addr_out` follows `addr_pin` and `addr_vld` equals chip select asserted.
- R10: Only a hardware reset clears `modes_locked` and returns both styles to their defaults.
- R11: `rd_stb` and `wr_stb` are never 1 together. All outputs follow the pins after two synchroniser stages plus one register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| cs_n | input | 1 | Chip select, active low |
| ctl_a_n | input | 1 | Read strobe, or data strobe in direction style |
| ctl_b_n | input | 1 | Write strobe, or direction (low = write) |
| ale | input | 1 | Address latch strobe (multiplexed style) |
| addr_pin | input | BUS_W | Address pins; bit 0 is used for detection |
| data_pin | input | BUS_W | Data pins; carry the address when multiplexed |
| rd_stb | output | 1 | Decoded internal read level |
| wr_stb | output | 1 | Decoded internal write level |
| addr_vld | output | 1 | Internal address valid |
| addr_out | output | BUS_W | Internal address |
| ctl_dirstb | output | 1 | 1 = direction-plus-strobe control style |
| bus_split | output | 1 | 1 = non-multiplexed bus |
| modes_locked | output | 1 | Both styles frozen until reset |

## Verification
Several rules hold cycle by cycle, and the assertions check them: the detection edges set the style flags, a chip-selected read locks, the lock is sticky, the frozen styles stay stable, read and write are mutually exclusive, nothing is decoded without chip select, and the address is captured on the address-strobe fall. Other behaviour only shows up as an order of events, so the bench scenarios cover it: a separate-strobe host on a non-multiplexed bus, and a direction-plus-strobe host on a multiplexed bus. They also cover detection from accesses to other devices, attempts to change modes after the lock, and a reset that brings back the defaults.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic {
    CTL_SPLIT  = 1'b0,
    CTL_DIRSTB = 1'b1
  } ctl_style_e;

  typedef enum logic {
    BUS_MUX   = 1'b0,
    BUS_SPLIT = 1'b1
  } bus_style_e;

  typedef struct packed {
    logic cs_n;
    logic a_n;
    logic b_n;
    logic ale;
  } ctl_pins_t;
endpackage

// File: rtl/hbd_rst_sync.sv
module hbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hbd_sync.sv
module hbd_sync #(
  parameter int              WIDTH   = 8,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_d;
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hbd_mode_detect.sv
module hbd_mode_detect
  import hbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_pins_t  pins,
  input  logic       a0,
  output ctl_style_e ctl_style,
  output bus_style_e bus_style,
  output logic       locked
);
  logic       a_prev_q;
  ctl_style_e ctl_q, ctl_d;
  bus_style_e bus_q, bus_d;
  logic       lock_q, lock_d;
  logic       upd_en;
  logic       a_fall, acc_lvl, rd_sel;

  assign a_fall  = a_prev_q & ~pins.a_n;
  assign acc_lvl = ~pins.a_n | ~pins.b_n;
  assign rd_sel  = ~pins.cs_n & ~pins.a_n & pins.b_n;
  assign upd_en  = ~lock_q;

  always_comb begin
    ctl_d  = ctl_q;
    bus_d  = bus_q;
    lock_d = lock_q;
    if (upd_en) begin
      if (a_fall && !pins.b_n) ctl_d = CTL_DIRSTB;
      if (acc_lvl && a0)       bus_d = BUS_SPLIT;
      if (rd_sel)              lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_prev_q <= 1'b1;
      ctl_q    <= CTL_SPLIT;
      bus_q    <= BUS_MUX;
      lock_q   <= 1'b0;
    end else begin
      a_prev_q <= pins.a_n;
      if (upd_en) begin
        ctl_q  <= ctl_d;
        bus_q  <= bus_d;
        lock_q <= lock_d;
      end
    end
  end

  assign ctl_style = ctl_q;
  assign bus_style = bus_q;
  assign locked    = lock_q;

  p_dirstb_detect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && a_fall && !pins.b_n) |=> (ctl_q == CTL_DIRSTB));

  p_split_detect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && acc_lvl && a0) |=> (bus_q == BUS_SPLIT));

  p_lock_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel |=> lock_q);

  p_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(ctl_q) && $stable(bus_q)));

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
endmodule

// File: rtl/hbd_decode.sv
module hbd_decode
  import hbd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_pins_t  pins,
  input  ctl_style_e ctl_style,
  output logic       rd_stb,
  output logic       wr_stb
);
  logic rd_d, wr_d, rd_q, wr_q;

  always_comb begin
    rd_d = ~pins.cs_n & ~pins.a_n & pins.b_n;
    if (ctl_style == CTL_DIRSTB) wr_d = ~pins.cs_n & ~pins.a_n & ~pins.b_n;
    else                         wr_d = ~pins.cs_n &  pins.a_n & ~pins.b_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
    end else begin
      rd_q <= rd_d;
      wr_q <= wr_d;
    end
  end

  assign rd_stb = rd_q;
  assign wr_stb = wr_q;

  p_rd_wr_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wr_q));

  p_no_cs_no_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pins.cs_n |=> (!rd_q && !wr_q));
endmodule

// File: rtl/hbd_addr_latch.sv
module hbd_addr_latch
  import hbd_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_pins_t        pins,
  input  bus_style_e       bus_style,
  input  logic [BUS_W-1:0] addr_pin,
  input  logic [BUS_W-1:0] data_pin,
  output logic [BUS_W-1:0] addr_out,
  output logic             addr_vld
);
  logic             ale_prev_q;
  logic [BUS_W-1:0] lat_q, lat_d;
  logic             flag_q, flag_d;
  logic [BUS_W-1:0] out_q, out_d;
  logic             vld_q, vld_d;
  logic             ale_fall, ale_rise, mux_en;

  assign ale_fall = ale_prev_q & ~pins.ale;
  assign ale_rise = ~ale_prev_q & pins.ale;
  assign mux_en   = (bus_style == BUS_MUX);

  always_comb begin
    lat_d  = lat_q;
    flag_d = flag_q;
    if (mux_en && ale_fall) begin
      lat_d  = data_pin;
      flag_d = 1'b1;
    end else if (ale_rise) begin
      flag_d = 1'b0;
    end
    if (mux_en) begin
      out_d = lat_d;
      vld_d = ~pins.cs_n & flag_d;
    end else begin
      out_d = addr_pin;
      vld_d = ~pins.cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_prev_q <= 1'b0;
      lat_q      <= '0;
      flag_q     <= 1'b0;
      out_q      <= '0;
      vld_q      <= 1'b0;
    end else begin
      ale_prev_q <= pins.ale;
      lat_q      <= lat_d;
      flag_q     <= flag_d;
      out_q      <= out_d;
      vld_q      <= vld_d;
    end
  end

  assign addr_out = out_q;
  assign addr_vld = vld_q;

  p_mux_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_en && ale_fall && !pins.cs_n) |=> (vld_q && out_q == $past(data_pin)));

  p_split_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mux_en && !pins.cs_n) |=> (vld_q && out_q == $past(addr_pin)));
endmodule

// File: rtl/host_bus_autodetect.sv
module host_bus_autodetect
  import hbd_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ctl_a_n,
  input  logic             ctl_b_n,
  input  logic             ale,
  input  logic [BUS_W-1:0] addr_pin,
  input  logic [BUS_W-1:0] data_pin,
  output logic             rd_stb,
  output logic             wr_stb,
  output logic             addr_vld,
  output logic [BUS_W-1:0] addr_out,
  output logic             ctl_dirstb,
  output logic             bus_split,
  output logic             modes_locked
);
  localparam int CTL_W = $bits(ctl_pins_t);
  localparam int SW    = CTL_W + 2 * BUS_W;
  localparam logic [SW-1:0] SYNC_RST = {4'b1110, {(2 * BUS_W){1'b0}}};

  logic             rst_n_i;
  logic [SW-1:0]    raw_vec, syn_vec;
  ctl_pins_t        pins_s;
  logic [BUS_W-1:0] addr_s, data_s;
  ctl_style_e       ctl_style;
  bus_style_e       bus_style;

  hbd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  assign raw_vec = {cs_n, ctl_a_n, ctl_b_n, ale, addr_pin, data_pin};

  hbd_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_i),
    .d     (raw_vec),
    .q     (syn_vec)
  );

  assign pins_s = ctl_pins_t'(syn_vec[SW-1 -: CTL_W]);
  assign addr_s = syn_vec[2*BUS_W-1 -: BUS_W];
  assign data_s = syn_vec[BUS_W-1:0];

  hbd_mode_detect u_mode (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .pins      (pins_s),
    .a0        (addr_s[0]),
    .ctl_style (ctl_style),
    .bus_style (bus_style),
    .locked    (modes_locked)
  );

  hbd_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .pins      (pins_s),
    .ctl_style (ctl_style),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb)
  );

  hbd_addr_latch #(.BUS_W(BUS_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .pins      (pins_s),
    .bus_style (bus_style),
    .addr_pin  (addr_s),
    .data_pin  (data_s),
    .addr_out  (addr_out),
    .addr_vld  (addr_vld)
  );

  assign ctl_dirstb = (ctl_style == CTL_DIRSTB);
  assign bus_split  = (bus_style == BUS_SPLIT);
endmodule

// File: tb/tb_host_bus_autodetect.sv
module tb_host_bus_autodetect;
  localparam int BUS_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             cs_n, ctl_a_n, ctl_b_n, ale;
  logic [BUS_W-1:0] addr_pin, data_pin;
  logic             rd_stb, wr_stb, addr_vld;
  logic [BUS_W-1:0] addr_out;
  logic             ctl_dirstb, bus_split, modes_locked;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  host_bus_autodetect #(.BUS_W(BUS_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ctl_a_n(ctl_a_n), .ctl_b_n(ctl_b_n),
    .ale(ale), .addr_pin(addr_pin), .data_pin(data_pin), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .addr_vld(addr_vld), .addr_out(addr_out),
    .ctl_dirstb(ctl_dirstb), .bus_split(bus_split), .modes_locked(modes_locked)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic idle();
    cs_n = 1'b1; ctl_a_n = 1'b1; ctl_b_n = 1'b1;
    settle();
  endtask

  task automatic hw_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cs_n = 1'b1; ctl_a_n = 1'b1; ctl_b_n = 1'b1; ale = 1'b0;
    addr_pin = '0; data_pin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_reset_state();
    hw_reset();
    chk("R1 ctl_dirstb", ctl_dirstb, 0);
    chk("R1 bus_split", bus_split, 0);
    chk("R1 modes_locked", modes_locked, 0);
    chk("R1 rd_stb", rd_stb, 0);
    chk("R1 wr_stb", wr_stb, 0);
    chk("R1 addr_vld", addr_vld, 0);
  endtask

  task automatic t_split_nonmux();
    addr_pin = 8'h35;
    ctl_b_n = 1'b0;                 // write to another device, odd address
    settle();
    chk("R3 bus_split after odd write", bus_split, 1);
    chk("R2 ctl_dirstb stays 0", ctl_dirstb, 0);
    chk("R7 wr_stb without cs", wr_stb, 0);
    idle();
    cs_n = 1'b0; ctl_b_n = 1'b0;
    settle();
    chk("R6 wr_stb split style", wr_stb, 1);
    chk("R11 rd_stb during write", rd_stb, 0);
    chk("R9 addr_vld", addr_vld, 1);
    chk("R9 addr_out", addr_out, 8'h35);
    idle();
    chk("R4 unlocked before read", modes_locked, 0);
    cs_n = 1'b0; ctl_a_n = 1'b0;
    settle();
    chk("R4 rd_stb", rd_stb, 1);
    chk("R4 modes_locked", modes_locked, 1);
    idle();
    ctl_b_n = 1'b0; settle();
    ctl_a_n = 1'b0; settle();
    chk("R5 ctl_dirstb frozen", ctl_dirstb, 0);
    chk("R5 bus_split frozen", bus_split, 1);
    idle();
  endtask

  task automatic t_reset_clears();
    hw_reset();
    chk("R10 locked cleared", modes_locked, 0);
    chk("R10 bus_split default", bus_split, 0);
    chk("R10 ctl_dirstb default", ctl_dirstb, 0);
  endtask

  task automatic t_dirstb_mux();
    addr_pin = '0;
    cs_n = 1'b0; ale = 1'b1; data_pin = 8'hA6;
    settle();
    ale = 1'b0;
    settle();
    chk("R8 addr_vld after ale fall", addr_vld, 1);
    chk("R8 addr_out captured", addr_out, 8'hA6);
    data_pin = 8'h11;
    ctl_b_n = 1'b0; settle();
    ctl_a_n = 1'b0; settle();
    chk("R2 ctl_dirstb detected", ctl_dirstb, 1);
    chk("R6 wr_stb dirstb style", wr_stb, 1);
    chk("R3 bus_split stays 0", bus_split, 0);
    chk("R8 addr_out held", addr_out, 8'hA6);
    ctl_a_n = 1'b1; settle();
    chk("R6 no write without data strobe", wr_stb, 0);
    ctl_b_n = 1'b1; settle();
    ctl_a_n = 1'b0; settle();
    chk("R4 rd_stb dirstb style", rd_stb, 1);
    chk("R4 locked", modes_locked, 1);
    ctl_a_n = 1'b1; settle();
    ale = 1'b1; settle();
    chk("R8 addr_vld drops on ale rise", addr_vld, 0);
    ale = 1'b0;
    addr_pin = 8'h01; ctl_b_n = 1'b0; ctl_a_n = 1'b0; settle();
    chk("R5 bus_split frozen", bus_split, 0);
    idle();
  endtask

  task automatic t_no_lock_without_cs();
    hw_reset();
    ctl_a_n = 1'b0; settle();
    chk("R7 rd_stb without cs", rd_stb, 0);
    chk("R7 no lock without cs", modes_locked, 0);
    idle();
    ctl_b_n = 1'b0; settle();
    ctl_a_n = 1'b0; settle();
    chk("R2 detect on other-device write", ctl_dirstb, 1);
    chk("R7 still unlocked", modes_locked, 0);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    t_reset_state();
    t_split_nonmux();
    t_reset_clears();
    t_dirstb_mux();
    t_no_lock_without_cs();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule